// File: doc/BRIEF.md
# Processor to DSP Expansion-Bus Glue

This block is synchronous glue between a big-endian embedded processor's local bus and the synchronous host port of a DSP expansion bus. Both sides share one bus clock. The processor is the bus master and the DSP port is the slave. The DSP owns bus arbitration, so the processor's own arbiter stays disabled and the processor asks for the bus through this glue.

On the transfer side, the glue decodes a chip select from the transfer-start strobe and the top address bits. It builds four active-low byte-lane enables from the transfer size and the two lowest address bits, and flags size and offset pairs it cannot express. It passes the start strobe, direction, burst and control-select lines straight across, and returns the DSP ready line as the processor's transfer acknowledge. The 32-bit data bus crosses with its bit numbering reversed, so the numeric value of a word is preserved.

On the arbitration side, bus request and bus busy are folded into a registered hold request. Hold acknowledge runs through a short register chain that shapes a two-clock bus grant pulse.

Top module: `xbus_glue`

## Requirements
- R1: A byte transfer (size code 01) drives byte-enable lane pattern `be_n` 0111, 1011, 1101, 1110 for offset {A30,A31} = 0, 1, 2, 3; `be_n` is combinational.
- R2: A half-word transfer (size 10) gives `be_n` 0011 at offset 0 and 1100 at offset 2. A word transfer (size 00) gives 0000 at offset 0.
- R3: `xb_cs_n` is low, combinationally, exactly when `cpu_ts_n` is low and processor address bits 0..2 (bit 0 is the MSB) equal 001.
- R4: `xb_hold` is high in the cycle after a clock edge that samples `cpu_br_n` or `cpu_bb_n` low. It is low after an edge that sees both high.
- R5: With `xb_holda` raised before clock edge E0, `cpu_bg_n` is still high after E0 and goes low after E1.
- R6: While `xb_holda` stays high, `cpu_bg_n` stays low for exactly two clocks (after E1 and E2) and is high again after E3. It never stays low for three consecutive cycles.
- R7: Processor data bit 0 (MSB) maps to expansion data bit 31, in both the write and the read direction, so word values pass unchanged.
- R8: `xb_as_n` follows `cpu_ts_n`, `xb_blast` follows `cpu_bdip`, and `xb_rnw` follows `cpu_rnw`. `xb_cntl` follows processor address bit 29, and `cpu_ta_n` follows `xb_rdy_n`, all combinationally.
- R9: Any size and offset pair not listed in R1/R2 (size 11, misaligned half-word, word at a non-zero offset) drives `be_n` to 1111. When such a pair arrives with a decoded chip select, `be_err` is high for the one cycle after that edge.
- R10: The active-high synchronous reset leaves `xb_hold` low, `cpu_bg_n` high and `be_err` low, even when applied in the middle of a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_ts_n | input | 1 | Processor transfer start, active low |
| cpu_addr | input | 32 | Processor address, bit 0 is MSB |
| cpu_tsize | input | 2 | Transfer size code (00 word, 01 byte, 10 half) |
| cpu_rnw | input | 1 | Processor read/write direction |
| cpu_bdip | input | 1 | Processor burst-in-progress |
| cpu_br_n | input | 1 | Processor bus request, active low |
| cpu_bb_n | input | 1 | Processor bus busy, active low |
| cpu_wdata | input | 32 | Processor write data, bit 0 is MSB |
| cpu_rdata | output | 32 | Read data to processor, bit 0 is MSB |
| cpu_ta_n | output | 1 | Transfer acknowledge to processor |
| cpu_bg_n | output | 1 | Bus grant to processor, active low |
| xb_cs_n | output | 1 | Expansion chip select, active low |
| xb_as_n | output | 1 | Expansion address strobe, active low |
| xb_cntl | output | 1 | Expansion control-select |
| xb_be_n | output | 4 | Expansion byte enables, active low |
| xb_rnw | output | 1 | Expansion read/write line |
| xb_blast | output | 1 | Expansion burst-last, active high |
| xb_wdata | output | 32 | Write data to expansion bus |
| xb_rdata | input | 32 | Read data from expansion bus |
| xb_rdy_n | input | 1 | Expansion ready, active low |
| xb_hold | output | 1 | Hold request to the DSP arbiter |
| xb_holda | input | 1 | Hold acknowledge from the DSP arbiter |
| be_err | output | 1 | One-cycle flag for an unsupported size/offset |

## Verification
The hardest state to reach is the shaped grant. The bench needs the register chain primed with acknowledge high across several consecutive edges, and then must catch a reset in the middle of that pulse. To get there, the bench raises the request, waits for the hold output, and holds the acknowledge steady. It samples the grant after each edge, E0 through E4, and then repeats the sequence with a reset dropped in right after the grant opens. The error flag is also awkward: it needs a decoded start that coincides with an illegal size. A table of all sixteen size and offset codes supplies this, and one directed start outside the region shows that the flag stays quiet.

// File: rtl/xbus_glue_pkg.sv
package xbus_glue_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef struct packed {
    logic [LANES-1:0] be_n;
    logic             legal;
  } lane_t;

  // Size plus offset lookup; unsupported pairs leave all lanes idle.
  function automatic lane_t lane_lookup(input logic [1:0] size, input logic [1:0] off);
    lane_t r;
    r.be_n  = '1;
    r.legal = 1'b0;
    case (size)
      SZ_BYTE: begin
        r.be_n  = ~(4'b1000 >> off);
        r.legal = 1'b1;
      end
      SZ_HALF: if (!off[0]) begin
        r.be_n  = off[1] ? 4'b1100 : 4'b0011;
        r.legal = 1'b1;
      end
      SZ_WORD: if (off == 2'b00) begin
        r.be_n  = 4'b0000;
        r.legal = 1'b1;
      end
      default: ;
    endcase
    return r;
  endfunction

  function automatic int lanes_for(input logic [1:0] size);
    case (size)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return LANES;
    endcase
  endfunction

endpackage

// File: rtl/xbg_select.sv
module xbg_select #(
  parameter int            REGION_BITS  = 3,
  parameter logic [REGION_BITS-1:0] REGION_MATCH = 3'b001
) (
  input  logic                   ts_n,
  input  logic [REGION_BITS-1:0] region,
  output logic                   hit,
  output logic                   cs_n
);
  assign hit  = (!ts_n) && (region == REGION_MATCH);
  assign cs_n = ~hit;
endmodule

// File: rtl/xbg_lanes.sv
module xbg_lanes
  import xbus_glue_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       size,
  input  logic [1:0]       off,
  input  logic             start_hit,
  output logic [LANES-1:0] be_n,
  output logic             err
);
  lane_t lk;
  logic  bad_start;

  assign lk        = lane_lookup(size, off);
  assign be_n      = lk.be_n;
  assign bad_start = start_hit && !lk.legal;

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= bad_start;
  end

  // Active lane count agrees with the size code whenever any lane is on.
  p_lane_count_r1: assert property (@(posedge clk) disable iff (rst)
    (be_n != 4'hF) |-> ($countones(~be_n) == lanes_for(size)));

  // A word never shows up on a partial lane set (R2).
  p_word_full_r2: assert property (@(posedge clk) disable iff (rst)
    ((size == SZ_WORD) && (be_n != 4'hF)) |-> (be_n == 4'h0));

  // Error flag only ever follows a decoded start.
  p_err_after_start_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(start_hit));

  p_err_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !start_hit |=> !err);
endmodule

// File: rtl/xbg_arbiter.sv
module xbg_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic br_n,
  input  logic bb_n,
  input  logic holda,
  output logic hold,
  output logic bg_n
);
  logic idle_q;                      // sampled AND of the two active-low requests
  logic ack_a, ack_b, ack_c, ack_d;  // acknowledge shaping chain
  logic grant_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= 1'b1;
      ack_a  <= 1'b0;
      ack_b  <= 1'b0;
      ack_c  <= 1'b0;
      ack_d  <= 1'b0;
    end else begin
      idle_q <= br_n & bb_n;
      ack_a  <= holda;
      ack_b  <= ack_a;
      ack_c  <= ack_a & ack_b;
      ack_d  <= ack_a & ack_c;
    end
  end

  assign hold      = ~idle_q;
  assign grant_win = ack_b & ~ack_d;
  assign bg_n      = ~grant_win;

  p_hold_follows_req_r4: assert property (@(posedge clk) disable iff (rst)
    (!br_n || !bb_n) |=> hold);

  p_hold_drops_r4: assert property (@(posedge clk) disable iff (rst)
    (br_n && bb_n) |=> !hold);

  p_grant_needs_ack_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(bg_n) |-> ack_a);

  p_grant_min_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(bg_n) |=> !bg_n);

  p_grant_max_r6: assert property (@(posedge clk) disable iff (rst)
    (!bg_n && $past(!bg_n)) |=> bg_n);
endmodule

// File: rtl/xbus_glue.sv
module xbus_glue
  import xbus_glue_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int REGION_BITS = 3,
  parameter int CNTL_BIT    = 29
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_ts_n,
  input  logic [0:AW-1]       cpu_addr,
  input  logic [1:0]          cpu_tsize,
  input  logic                cpu_rnw,
  input  logic                cpu_bdip,
  input  logic                cpu_br_n,
  input  logic                cpu_bb_n,
  input  logic [0:DW-1]       cpu_wdata,
  output logic [0:DW-1]       cpu_rdata,
  output logic                cpu_ta_n,
  output logic                cpu_bg_n,
  output logic                xb_cs_n,
  output logic                xb_as_n,
  output logic                xb_cntl,
  output logic [LANES-1:0]    xb_be_n,
  output logic                xb_rnw,
  output logic                xb_blast,
  output logic [DW-1:0]       xb_wdata,
  input  logic [DW-1:0]       xb_rdata,
  input  logic                xb_rdy_n,
  output logic                xb_hold,
  input  logic                xb_holda,
  output logic                be_err
);
  localparam int OFF_HI = AW - 2;
  localparam int OFF_LO = AW - 1;

  logic       start_hit;
  logic [1:0] offset;

  assign offset = {cpu_addr[OFF_HI], cpu_addr[OFF_LO]};

  xbg_select #(.REGION_BITS(REGION_BITS), .REGION_MATCH(3'b001)) u_sel (
    .ts_n   (cpu_ts_n),
    .region (cpu_addr[0:REGION_BITS-1]),
    .hit    (start_hit),
    .cs_n   (xb_cs_n)
  );

  xbg_lanes u_lanes (
    .clk       (clk),
    .rst       (rst),
    .size      (cpu_tsize),
    .off       (offset),
    .start_hit (start_hit),
    .be_n      (xb_be_n),
    .err       (be_err)
  );

  xbg_arbiter u_arb (
    .clk   (clk),
    .rst   (rst),
    .br_n  (cpu_br_n),
    .bb_n  (cpu_bb_n),
    .holda (xb_holda),
    .hold  (xb_hold),
    .bg_n  (cpu_bg_n)
  );

  // Straight-through strobes.
  assign xb_as_n  = cpu_ts_n;
  assign xb_blast = cpu_bdip;
  assign xb_rnw   = cpu_rnw;
  assign xb_cntl  = cpu_addr[CNTL_BIT];
  assign cpu_ta_n = xb_rdy_n;

  // Bit numbering flips between the two data buses.
  for (genvar i = 0; i < DW; i++) begin : g_swap
    assign xb_wdata[DW-1-i] = cpu_wdata[i];
    assign cpu_rdata[i]     = xb_rdata[DW-1-i];
  end

  p_cs_needs_start_r3: assert property (@(posedge clk) disable iff (rst)
    !xb_cs_n |-> !cpu_ts_n);

  p_cs_region_r3: assert property (@(posedge clk) disable iff (rst)
    !xb_cs_n |-> (cpu_addr[0:REGION_BITS-1] == 3'b001));

  p_grant_quiet_after_reset_r10: assert property (@(posedge clk)
    $past(rst) |-> (cpu_bg_n && !xb_hold && !be_err));
endmodule

// File: tb/xbus_glue_tb.sv
module xbus_glue_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_ts_n, cpu_rnw, cpu_bdip, cpu_br_n, cpu_bb_n;
  logic [0:31] cpu_addr, cpu_wdata, cpu_rdata;
  logic [1:0]  cpu_tsize;
  logic        cpu_ta_n, cpu_bg_n, xb_cs_n, xb_as_n, xb_cntl, xb_rnw, xb_blast;
  logic [3:0]  xb_be_n;
  logic [31:0] xb_wdata, xb_rdata;
  logic        xb_rdy_n, xb_hold, xb_holda, be_err;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;   // 50 MHz

  xbus_glue u_dut (
    .clk(clk), .rst(rst), .cpu_ts_n(cpu_ts_n), .cpu_addr(cpu_addr),
    .cpu_tsize(cpu_tsize), .cpu_rnw(cpu_rnw), .cpu_bdip(cpu_bdip),
    .cpu_br_n(cpu_br_n), .cpu_bb_n(cpu_bb_n), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ta_n(cpu_ta_n), .cpu_bg_n(cpu_bg_n),
    .xb_cs_n(xb_cs_n), .xb_as_n(xb_as_n), .xb_cntl(xb_cntl), .xb_be_n(xb_be_n),
    .xb_rnw(xb_rnw), .xb_blast(xb_blast), .xb_wdata(xb_wdata),
    .xb_rdata(xb_rdata), .xb_rdy_n(xb_rdy_n), .xb_hold(xb_hold),
    .xb_holda(xb_holda), .be_err(be_err)
  );

  // {size[1:0], off[1:0], be_n[3:0], err}
  localparam logic [8:0] VEC [16] = '{
    {2'b00, 2'd0, 4'b0000, 1'b0}, {2'b00, 2'd1, 4'b1111, 1'b1},
    {2'b00, 2'd2, 4'b1111, 1'b1}, {2'b00, 2'd3, 4'b1111, 1'b1},
    {2'b01, 2'd0, 4'b0111, 1'b0}, {2'b01, 2'd1, 4'b1011, 1'b0},
    {2'b01, 2'd2, 4'b1101, 1'b0}, {2'b01, 2'd3, 4'b1110, 1'b0},
    {2'b10, 2'd0, 4'b0011, 1'b0}, {2'b10, 2'd1, 4'b1111, 1'b1},
    {2'b10, 2'd2, 4'b1100, 1'b0}, {2'b10, 2'd3, 4'b1111, 1'b1},
    {2'b11, 2'd0, 4'b1111, 1'b1}, {2'b11, 2'd1, 4'b1111, 1'b1},
    {2'b11, 2'd2, 4'b1111, 1'b1}, {2'b11, 2'd3, 4'b1111, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic after_edge();
    @(posedge clk); #2;
  endtask

  function automatic logic [0:31] mk_addr(input logic [2:0] region, input logic cntl,
                                          input logic [1:0] off);
    return {region, 26'd0, cntl, off};
  endfunction

  initial begin : watchdog
    #(4_000_000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; cpu_ts_n = 1'b1; cpu_rnw = 1'b1; cpu_bdip = 1'b0;
    cpu_br_n = 1'b1; cpu_bb_n = 1'b1; cpu_addr = '0; cpu_tsize = 2'b00;
    cpu_wdata = '0; xb_rdata = '0; xb_rdy_n = 1'b1; xb_holda = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    check("R10 hold", 32'(xb_hold), 32'd0);
    check("R10 grant", 32'(cpu_bg_n), 32'd1);
    check("R10 err", 32'(be_err), 32'd0);
    @(negedge clk); rst = 1'b0;

    // R1 R2 R9: walk every size/offset code
    foreach (VEC[i]) begin
      @(negedge clk);
      cpu_ts_n  = 1'b0;
      cpu_tsize = VEC[i][8:7];
      cpu_addr  = mk_addr(3'b001, 1'b0, VEC[i][6:5]);
      #2;
      check(VEC[i][0] ? "R9 be_n idle" : (VEC[i][8:7] == 2'b01 ? "R1 be_n" : "R2 be_n"),
            32'(xb_be_n), 32'(VEC[i][4:1]));
      after_edge();
      check("R9 err pulse", 32'(be_err), 32'(VEC[i][0]));
      @(negedge clk); cpu_ts_n = 1'b1;
      after_edge();
      check("R9 err one cycle", 32'(be_err), 32'd0);
    end

    // R9: illegal size outside the region raises no flag
    @(negedge clk);
    cpu_ts_n = 1'b0; cpu_tsize = 2'b11; cpu_addr = mk_addr(3'b010, 1'b0, 2'd1);
    after_edge();
    check("R9 no flag off-region", 32'(be_err), 32'd0);

    // R3: chip select decode
    @(negedge clk); cpu_addr = mk_addr(3'b001, 1'b0, 2'd0); cpu_tsize = 2'b00; #2;
    check("R3 cs hit", 32'(xb_cs_n), 32'd0);
    cpu_ts_n = 1'b1; #2;
    check("R3 cs needs start", 32'(xb_cs_n), 32'd1);
    cpu_ts_n = 1'b0;
    for (int r = 0; r < 8; r++) begin
      cpu_addr = mk_addr(3'(r), 1'b0, 2'd0); #2;
      check("R3 region", 32'(xb_cs_n), (r == 1) ? 32'd0 : 32'd1);
    end
    cpu_ts_n = 1'b1;

    // R7 R8: four-beat burst read then write
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cpu_ts_n = (k != 0); cpu_rnw = 1'b1; cpu_bdip = (k != 3);
      cpu_addr = mk_addr(3'b001, k[0], 2'd0);
      xb_rdata = 32'h4444_4444 + 32'h1111_1111 * k; xb_rdy_n = 1'b0;
      #2;
      check("R7 read data", cpu_rdata, 32'h4444_4444 + 32'h1111_1111 * k);
      check("R8 ta", 32'(cpu_ta_n), 32'd0);
      check("R8 blast", 32'(xb_blast), 32'(k != 3));
      check("R8 as", 32'(xb_as_n), 32'(k != 0));
      check("R8 cntl", 32'(xb_cntl), 32'(k[0]));
      check("R8 rnw", 32'(xb_rnw), 32'd1);
    end
    @(negedge clk); xb_rdy_n = 1'b1; #2;
    check("R8 ta idle", 32'(cpu_ta_n), 32'd1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cpu_rnw = 1'b0; cpu_bdip = (k != 3);
      cpu_wdata = (32'h0000_0001 << k) | 32'h8000_0000;
      #2;
      check("R7 write data", xb_wdata, (32'h0000_0001 << k) | 32'h8000_0000);
      check("R8 rnw write", 32'(xb_rnw), 32'd0);
    end
    cpu_bdip = 1'b0; cpu_rnw = 1'b1;

    // R4: request through bus request
    @(negedge clk); cpu_br_n = 1'b0; #2;
    check("R4 hold not yet", 32'(xb_hold), 32'd0);
    after_edge();
    check("R4 hold via br", 32'(xb_hold), 32'd1);
    // R5 R6: grant shaping
    @(negedge clk); cpu_br_n = 1'b1; xb_holda = 1'b1;
    after_edge();
    check("R4 hold released", 32'(xb_hold), 32'd0);
    check("R5 grant after E0", 32'(cpu_bg_n), 32'd1);
    after_edge(); check("R5 grant after E1", 32'(cpu_bg_n), 32'd0);
    after_edge(); check("R6 grant after E2", 32'(cpu_bg_n), 32'd0);
    after_edge(); check("R6 grant after E3", 32'(cpu_bg_n), 32'd1);
    after_edge(); check("R6 grant after E4", 32'(cpu_bg_n), 32'd1);
    @(negedge clk); xb_holda = 1'b0;
    repeat (4) @(posedge clk);

    // R4: request through bus busy
    @(negedge clk); cpu_bb_n = 1'b0;
    after_edge(); check("R4 hold via bb", 32'(xb_hold), 32'd1);

    // R10: reset in the middle of a grant
    @(negedge clk); xb_holda = 1'b1;
    after_edge(); after_edge();
    check("R5 grant before reset", 32'(cpu_bg_n), 32'd0);
    @(negedge clk); rst = 1'b1;
    after_edge();
    check("R10 grant cleared", 32'(cpu_bg_n), 32'd1);
    check("R10 hold cleared", 32'(xb_hold), 32'd0);
    @(negedge clk); rst = 1'b0; xb_holda = 1'b0; cpu_bb_n = 1'b1;
    repeat (3) @(posedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule